// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable serial nonvolatile memory slave holding 4096 bits. A host drives a chip select, a serial clock and a serial data line. The block answers on a serial data output that has its own enable for a tri-state pad. All pins are sampled in the system clock domain, and the serial clock is expected to run well below the system clock. A width-select input arranges the array either as 256 words of 16 bits or as 512 bytes.

Each instruction opens with a start bit, then carries an opcode, an address and, for programming commands, a data word. Seven commands exist: read, single-word write, single-word erase, program enable, program disable, erase everything and write everything. Programming is guarded by an enable latch and starts when chip select falls. It then runs from an internal counter for a fixed number of system clocks. While it runs, and chip select is high, the output reports busy or ready. Reads stream words back to back for as long as chip select stays high.

Top module: `ee3w_slave`

## Requirements
- R1: With `org_wide` high, the array is 256 words of 16 bits with 8 address bits. With it low, the array is 512 bytes with 9 address bits, and byte address bit 0 picks the upper half (1) or the lower half (0) of the 16-bit word at byte address bits 8..1.
- R2: A frame is a 1 start bit, then a 2-bit opcode, then the address MSB first, then, for write and write-all, the data MSB first (16 bits wide, 8 bits narrow). Opcode 10 reads, 01 writes, 11 erases. Opcode 00 selects by the two top address bits: 11 enables programming, 00 disables it, 10 erases everything, 01 writes everything.
- R3: Zeros seen before the start bit are skipped. A frame cut short by chip select falling is discarded and changes nothing.
- R4: After the last address bit of a read, `sdo` shows a 0 dummy bit. Each later rising serial clock edge presents the next data bit, MSB first.
- R5: While chip select stays high, a read continues with the next address after each word, wrapping from the last address of the current width to 0.
- R6: After reset, programming is disabled. Write, erase, erase-all and write-all leave the array unchanged until an enable is received, and again after a disable.
- R7: Read returns the stored data whether programming is enabled or not.
- R8: A complete programming command starts on the falling edge of chip select, needs no serial clock, and stays busy for `PROG_CYCLES` system clocks.
- R9: Erase sets the addressed word to all ones. Write replaces the addressed word with the new data, whatever it held before.
- R10: Erase-all sets every bit to 1. Write-all stores the supplied data in every word; in byte mode, the byte fills both halves of every 16-bit word.
- R11: `sdo_en` is low while chip select is low. With chip select high, `sdo` reads 0 while programming runs and 1 once it has finished.
- R12: Frames shifted in while programming runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| org_wide | input | 1 | 1: 16-bit words, 0: bytes |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data or busy/ready status |
| sdo_en | output | 1 | Output enable for `sdo` |

## Verification
Random single-word writes go to random addresses in both widths and are read back in both widths. This separates a wrong lane choice or address slice from a wrong data path. Sequential reads that start at the last address of each width catch wrap errors, which a read of one word cannot show. Directed frames cover the disabled latch, leading zeros, truncation, commands issued while busy, and bulk operations in byte mode. Each of those leaves a visible trace in a later read. The busy window is also measured against `PROG_CYCLES`.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_DEC, S_DATA, S_ARM, S_READ, S_BUSY
  } ee_state_t;

  typedef enum logic [2:0] {
    K_NONE, K_READ, K_WRITE, K_ERASE, K_ERAL, K_WRAL
  } ee_kind_t;

  function automatic logic is_prog(ee_kind_t k);
    return (k == K_WRITE) || (k == K_ERASE) || (k == K_ERAL) || (k == K_WRAL);
  endfunction
endpackage

// File: rtl/ee3w_pins.sv
module ee3w_pins #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sck,
  input  logic sdi,
  output logic cs_lvl,
  output logic sk_rise,
  output logic di_lvl
);
  logic [STAGES:0] cs_p, sk_p, di_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p <= '0;
      sk_p <= '0;
      di_p <= '0;
    end else begin
      cs_p <= {cs_p[STAGES-1:0], cs};
      sk_p <= {sk_p[STAGES-1:0], sck};
      di_p <= {di_p[STAGES-1:0], sdi};
    end
  end

  assign cs_lvl  = cs_p[STAGES-1];
  assign sk_rise = sk_p[STAGES-1] & ~sk_p[STAGES];
  assign di_lvl  = di_p[STAGES-1];
endmodule

// File: rtl/ee3w_ram.sv
module ee3w_ram #(
  parameter int AW    = 8,
  parameter int LW    = 8,
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic [LANES-1:0]      we,
  input  logic [AW-1:0]         waddr,
  input  logic [LANES*LW-1:0]   wdata,
  input  logic [AW-1:0]         raddr,
  output logic [LANES*LW-1:0]   rdata
);
  localparam int NW = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [NW];
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LW +: LW];
      rdata[g*LW +: LW] <= mem[raddr];
    end
  end
endmodule

// File: rtl/ee3w_slave.sv
module ee3w_slave
  import ee3w_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int AW          = 8,
  parameter int PROG_CYCLES = 300,
  parameter int SYNC        = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic org_wide,
  input  logic cs,
  input  logic sck,
  input  logic sdi,
  output logic sdo,
  output logic sdo_en
);
  localparam int BW  = WORD_W / 2;
  localparam int AWN = AW + 1;
  localparam int NW  = 1 << AW;
  localparam int HW  = AWN + 2;
  localparam int CW  = $clog2(((WORD_W > HW) ? WORD_W : HW) + 1);
  localparam int TW  = $clog2(PROG_CYCLES + 1);

  logic cs_lvl, sk_rise, di_lvl;
  ee3w_pins #(.STAGES(SYNC)) u_pins (
    .clk(clk), .rst(rst), .cs(cs), .sck(sck), .sdi(sdi),
    .cs_lvl(cs_lvl), .sk_rise(sk_rise), .di_lvl(di_lvl)
  );

  ee_state_t        st;
  ee_kind_t         kind;
  logic [HW-1:0]    hdr;
  logic [CW-1:0]    cnt;
  logic [WORD_W-1:0] dsh, osh;
  logic [AWN-1:0]   addr;
  logic [TW-1:0]    tmr;
  logic             wen, rdy, sdo_r, en_r;

  // frame decode, valid while st == S_DEC
  logic [1:0]     op, sub;
  logic [AWN-1:0] a_dec;
  logic [CW-1:0]  hdr_len, dat_len;
  assign op      = org_wide ? hdr[AW+1:AW] : hdr[AW+2:AW+1];
  assign sub     = org_wide ? hdr[AW-1:AW-2] : hdr[AW:AW-1];
  assign a_dec   = org_wide ? {1'b0, hdr[AW-1:0]} : hdr[AWN-1:0];
  assign hdr_len = org_wide ? CW'(AW + 2) : CW'(AW + 3);
  assign dat_len = org_wide ? CW'(WORD_W) : CW'(BW);

  // array port
  logic [1:0]        ram_we;
  logic [AW-1:0]     ram_wa, ram_ra;
  logic [WORD_W-1:0] ram_wd, ram_rd;
  logic [WORD_W-1:0] fill;
  logic              busy_w, dec_w;

  assign busy_w = (st == S_BUSY);
  assign dec_w  = (st == S_DEC);
  assign fill   = org_wide ? dsh : {dsh[BW-1:0], dsh[BW-1:0]};
  assign ram_ra = org_wide ? addr[AW-1:0] : addr[AW:1];

  always_comb begin
    ram_we = 2'b00;
    ram_wa = org_wide ? addr[AW-1:0] : addr[AW:1];
    ram_wd = '1;
    if (busy_w) begin
      if ((kind == K_ERAL) || (kind == K_WRAL)) begin
        ram_wa = tmr[AW-1:0];
        ram_wd = (kind == K_WRAL) ? fill : '1;
        if (32'(tmr) < NW) ram_we = 2'b11;
      end else if (tmr == '0) begin
        ram_wd = (kind == K_WRITE) ? fill : '1;
        ram_we = org_wide ? 2'b11 : (addr[0] ? 2'b10 : 2'b01);
      end
    end
  end

  ee3w_ram #(.AW(AW), .LW(BW), .LANES(2)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_wa), .wdata(ram_wd),
    .raddr(ram_ra), .rdata(ram_rd)
  );

  // word presented to the output shifter, left aligned
  logic [WORD_W-1:0] out_word;
  logic [AWN-1:0]    addr_nx;
  assign out_word = org_wide ? ram_rd
                  : {(addr[0] ? ram_rd[WORD_W-1:BW] : ram_rd[BW-1:0]), {BW{1'b0}}};
  assign addr_nx  = org_wide ? {1'b0, addr[AW-1:0] + 1'b1} : addr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      kind  <= K_NONE;
      hdr   <= '0;
      cnt   <= '0;
      dsh   <= '0;
      osh   <= '0;
      addr  <= '0;
      tmr   <= '0;
      wen   <= 1'b0;
      rdy   <= 1'b0;
      sdo_r <= 1'b0;
      en_r  <= 1'b0;
    end else begin
      en_r <= cs_lvl & ((st == S_READ) || (st == S_BUSY) || ((st == S_IDLE) && rdy));
      unique case (st)
        S_IDLE: begin
          if (rdy) sdo_r <= 1'b1;
          if (cs_lvl && sk_rise && di_lvl) begin
            st  <= S_HDR;
            cnt <= '0;
            rdy <= 1'b0;
          end
        end
        S_HDR: begin
          if (!cs_lvl) st <= S_IDLE;
          else if (sk_rise) begin
            hdr <= {hdr[HW-2:0], di_lvl};
            cnt <= cnt + 1'b1;
            if (cnt + 1'b1 == hdr_len) st <= S_DEC;
          end
        end
        S_DEC: begin
          addr <= a_dec;
          cnt  <= '0;
          kind <= K_NONE;
          st   <= S_ARM;
          unique case (op)
            2'b10: begin kind <= K_READ; sdo_r <= 1'b0; st <= S_READ; end
            2'b01: begin kind <= K_WRITE; st <= S_DATA; end
            2'b11: kind <= K_ERASE;
            default: unique case (sub)
              2'b11:   wen <= 1'b1;
              2'b00:   wen <= 1'b0;
              2'b10:   kind <= K_ERAL;
              default: begin kind <= K_WRAL; st <= S_DATA; end
            endcase
          endcase
        end
        S_DATA: begin
          if (!cs_lvl) st <= S_IDLE;
          else if (sk_rise) begin
            dsh <= {dsh[WORD_W-2:0], di_lvl};
            cnt <= cnt + 1'b1;
            if (cnt + 1'b1 == dat_len) st <= S_ARM;
          end
        end
        S_ARM: begin
          tmr <= '0;
          if (!cs_lvl) st <= (wen && is_prog(kind)) ? S_BUSY : S_IDLE;
        end
        S_READ: begin
          if (!cs_lvl) st <= S_IDLE;
          else if (sk_rise) begin
            if (cnt == '0) begin
              sdo_r <= out_word[WORD_W-1];
              osh   <= out_word << 1;
              cnt   <= 1;
            end else begin
              sdo_r <= osh[WORD_W-1];
              osh   <= osh << 1;
              if (cnt == dat_len - 1'b1) begin
                cnt  <= '0;
                addr <= addr_nx;
              end else cnt <= cnt + 1'b1;
            end
          end
        end
        S_BUSY: begin
          sdo_r <= 1'b0;
          tmr   <= tmr + 1'b1;
          if (tmr == TW'(PROG_CYCLES - 1)) begin
            st  <= S_IDLE;
            rdy <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sdo    = sdo_r;
  assign sdo_en = en_r;
endmodule

// File: rtl/ee3w_chk.sv
module ee3w_chk #(
  parameter int PROG_CYCLES = 300
) (
  input logic       clk,
  input logic       rst,
  input logic       cs_lvl,
  input logic       busy,
  input logic       dec,
  input logic       wen,
  input logic [1:0] ram_we,
  input logic       sdo,
  input logic       sdo_en,
  input logic [$clog2(PROG_CYCLES+1)-1:0] tmr
);
  // R11: output released once chip select is low
  p_hiz_r11: assert property (@(posedge clk) disable iff (rst)
    !cs_lvl |=> !sdo_en);

  // R11: busy shows as 0 on the pin
  p_busy_low_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && sdo_en) |-> !sdo);

  // R6: array changes only while programming is enabled
  p_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (ram_we != 2'b00) |-> wen);

  // R8: array changes only inside a program cycle
  p_we_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (ram_we != 2'b00) |-> busy);

  // R6: enable latch moves only after a decoded frame
  p_wen_src_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(wen) || $fell(wen)) |-> $past(dec));

  // R8: program cycle ends only after its full count
  p_busy_len_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (int'($past(tmr)) == PROG_CYCLES - 1));
endmodule

bind ee3w_slave ee3w_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .cs_lvl(cs_lvl), .busy(busy_w), .dec(dec_w),
  .wen(wen), .ram_we(ram_we), .sdo(sdo), .sdo_en(sdo_en), .tmr(tmr)
);

// File: tb/sim_ee3w_slave.sv
module sim_ee3w_slave;
  localparam int PROG = 300;
  localparam int HALF = 4;

  logic clk = 0, rst = 1, org_wide = 1, cs = 0, sck = 0, sdi = 0;
  logic sdo, sdo_en;
  int total = 0, bad = 0;
  logic [7:0] mdl [512];
  logic done = 0;

  always #4 clk = ~clk;

  ee3w_slave #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst(rst), .org_wide(org_wide), .cs(cs), .sck(sck),
    .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(bit b);
    sdi = b; tick(HALF); sck = 1; tick(HALF); sck = 0;
  endtask

  task automatic cs_on();  cs = 1; tick(HALF); endtask
  task automatic cs_off(); cs = 0; sdi = 0; tick(HALF); endtask

  function automatic int abits(); return org_wide ? 8 : 9; endfunction
  function automatic int dbits(); return org_wide ? 16 : 8; endfunction
  function automatic int amask(); return org_wide ? 255 : 511; endfunction

  function automatic logic [15:0] exp_word(int a);
    if (org_wide) return {mdl[2*a+1], mdl[2*a]};
    return {8'h00, mdl[a]};
  endfunction

  function automatic void mdl_put(int a, logic [15:0] d);
    if (org_wide) begin mdl[2*a] = d[7:0]; mdl[2*a+1] = d[15:8]; end
    else mdl[a] = d[7:0];
  endfunction

  function automatic logic [8:0] subaddr(bit [1:0] s);
    return org_wide ? {1'b0, s, 6'b0} : {s, 7'b0};
  endfunction

  task automatic send_hdr(bit [1:0] op, logic [8:0] a);
    sbit(1); sbit(op[1]); sbit(op[0]);
    for (int i = abits() - 1; i >= 0; i--) sbit(a[i]);
  endtask

  task automatic send_data(logic [15:0] d, int n);
    for (int i = n - 1; i >= 0; i--) sbit(d[i]);
  endtask

  // wait for ready with chip select high; optionally check the duration
  task automatic prog_wait(string req, bit timed);
    int t;
    t = 2 * HALF + 2;
    cs_on(); tick(2);
    chk({req, " busy"}, {14'b0, sdo_en, sdo}, 16'h0002);
    while (!(sdo_en && sdo) && t < 4 * PROG) begin tick(1); t++; end
    chk({req, " ready"}, {15'b0, sdo}, 16'h0001);
    if (timed) begin
      total++;
      if (t < PROG || t > PROG + 12) begin
        bad++;
        $display("FAIL R8 program length: actual=%0d expected=%0d..%0d", t, PROG, PROG + 12);
      end
    end
    cs_off();
  endtask

  task automatic sub_cmd(bit [1:0] s);
    cs_on(); send_hdr(2'b00, subaddr(s)); cs_off();
  endtask

  task automatic wr(int a, logic [15:0] d, bit en);
    cs_on(); send_hdr(2'b01, 9'(a)); send_data(d, dbits()); cs_off();
    if (en) begin
      if (!org_wide) d = {8'h00, d[7:0]};
      mdl_put(a, d);
      prog_wait("R8 write", 0);
    end else tick(PROG + 20);
  endtask

  task automatic rd_chk(int a, int nw, int lead, string req);
    logic [15:0] got;
    cs_on();
    for (int i = 0; i < lead; i++) sbit(0);
    send_hdr(2'b10, 9'(a));
    tick(2);
    chk({req, " R4 dummy"}, {14'b0, sdo_en, sdo}, 16'h0002);
    for (int w = 0; w < nw; w++) begin
      got = '0;
      for (int b = 0; b < dbits(); b++) begin
        sck = 1; tick(HALF);
        got = {got[14:0], sdo};
        sck = 0; tick(HALF);
      end
      chk(req, got, exp_word(a));
      a = (a + 1) & amask();
    end
    cs_off();
  endtask

  initial begin
    void'($urandom(32'h1234_5a5a));
    tick(4); rst = 0; tick(4);
    chk("R11 reset hi-z", {15'b0, sdo_en}, 16'h0000);

    // enable, erase everything, check timing and contents
    sub_cmd(2'b11);
    cs_on(); send_hdr(2'b00, subaddr(2'b10)); cs_off();
    for (int i = 0; i < 512; i++) mdl[i] = 8'hFF;
    prog_wait("R11 R10 eral", 1);
    rd_chk(5, 1, 0, "R10 erase-all");

    // disabled latch blocks writes, read still works
    sub_cmd(2'b00);
    wr(3, 16'h1234, 0);
    rd_chk(3, 1, 0, "R6 R7 R2 write while disabled");
    sub_cmd(2'b11);

    // random writes and readbacks in both widths
    for (int i = 0; i < 12; i++) begin
      org_wide = 1'($urandom_range(0, 1));
      wr(int'($urandom_range(0, amask())), 16'($urandom), 1);
    end
    for (int i = 0; i < 10; i++) begin
      org_wide = 1'($urandom_range(0, 1));
      rd_chk(int'($urandom_range(0, amask())), 1, 0, "R1 R9 random readback");
    end

    // directed lane mapping and overwrite
    org_wide = 1; wr(20, 16'hBEEF, 1);
    org_wide = 0; rd_chk(41, 1, 0, "R1 upper byte");
    rd_chk(40, 1, 0, "R1 lower byte");
    wr(40, 16'h0011, 1);
    org_wide = 1; rd_chk(20, 1, 0, "R9 R1 byte overwrite");

    // erase one byte
    org_wide = 0;
    cs_on(); send_hdr(2'b11, 9'd41); cs_off();
    mdl[41] = 8'hFF;
    prog_wait("R9 erase", 0);
    org_wide = 1; rd_chk(20, 1, 0, "R9 erase byte");

    // sequential read and wrap
    wr(255, 16'h0F0F, 1); wr(0, 16'h7070, 1);
    rd_chk(254, 4, 0, "R5 wrap wide");
    org_wide = 0; wr(511, 16'h00C3, 1);
    rd_chk(510, 3, 0, "R5 wrap byte");

    // leading zeros before the start bit
    rd_chk(511, 1, 3, "R3 leading zeros");

    // truncated frame
    org_wide = 1;
    cs_on(); send_hdr(2'b01, 9'd9); send_data(16'h00A0, 5); cs_off();
    tick(PROG + 20);
    rd_chk(9, 1, 0, "R3 truncated");

    // frame during busy is ignored
    cs_on(); send_hdr(2'b01, 9'd12); send_data(16'h4321, 16); cs_off();
    mdl_put(12, 16'h4321);
    cs_on(); tick(2);
    chk("R11 busy", {15'b0, sdo}, 16'h0000);
    send_hdr(2'b01, 9'd13); send_data(16'h9999, 16); cs_off();
    prog_wait("R12 after", 0);
    rd_chk(12, 2, 0, "R12 busy ignore");

    // write-all in byte mode fills both halves
    org_wide = 0;
    cs_on(); send_hdr(2'b00, subaddr(2'b01)); send_data(16'h005A, 8); cs_off();
    for (int i = 0; i < 512; i++) mdl[i] = 8'h5A;
    prog_wait("R10 wral", 1);
    org_wide = 1; rd_chk(7, 2, 0, "R10 write-all byte fill");

    // write-all wide
    cs_on(); send_hdr(2'b00, subaddr(2'b01)); send_data(16'hA5C3, 16); cs_off();
    for (int i = 0; i < 256; i++) mdl_put(i, 16'hA5C3);
    prog_wait("R10 wral", 0);
    rd_chk(200, 1, 0, "R10 write-all wide");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule